// File: doc/BRIEF.md
# Hash Engine Status and Interrupt Register

This block holds the 32-bit status word of a hash accelerator and derives its interrupt request. The hash core, input FIFO and DMA engine are outside it; they appear only as event and level inputs. Two of the bits are live mirrors: the core's busy signal, and a DMA activity indication. The other two are sticky flags that hardware sets and software clears. One flag reports that a digest is ready. The other reports that the input buffer can take a full new block.

Software reads the word at any time; reads have no side effect. A bus write to the status register clears a sticky flag where the written bit is 0 and leaves it alone where the bit is 1. Each flag also has a second clear path. The digest flag clears when INIT is written as 1. The input flag clears on any write to the data-input register. The interrupt request is a registered level: it is high while any sticky flag is set together with its enable mask bit.

Top module: `hsr_top`

## Requirements
- R1: After reset the read value is 0x0000_0001. Bits 31:4 always read as 0.
- R2: Read bit 3 equals `core_busy_i` in the same cycle.
- R3: Read bit 2 is 1 when `dma_en_i` or `dma_xfer_i` is 1, and 0 only when both are 0. It never affects `irq_o`.
- R4: A `digest_done_i` pulse sets read bit 1 at the next clock edge.
- R5: Read bit 1 clears at the next edge after a status write with data bit 1 equal to 0, or after an `init_i` pulse.
- R6: Read bit 0 is set at the edge where `fifo_free_i` goes from below 16 to 16 or more.
- R7: Read bit 0 clears at the next edge after a status write with data bit 0 equal to 0, or after a `din_wr_i` pulse.
- R8: Writing 1 to bit 0 or bit 1 leaves that flag unchanged. A write that clears one flag leaves the other unchanged.
- R9: When a set event and a clear of the same flag fall in one cycle, the flag ends set.
- R10: `irq_o` is registered. After each edge it equals (bit 1 AND `ie_digest_i`) OR (bit 0 AND `ie_din_i`), evaluated on the flag and mask values before that edge.
- R11: Once cleared, bit 0 stays 0 while `fifo_free_i` stays at 16 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| core_busy_i | input | 1 | Core is processing a block |
| digest_done_i | input | 1 | One-cycle pulse: digest available |
| fifo_free_i | input | 5 | Number of free input buffer locations |
| dma_en_i | input | 1 | DMA enable control bit |
| dma_xfer_i | input | 1 | A DMA transfer is ongoing |
| init_i | input | 1 | One-cycle pulse: INIT written as 1 |
| ie_digest_i | input | 1 | Interrupt enable for digest flag |
| ie_din_i | input | 1 | Interrupt enable for input-ready flag |
| stat_wr_i | input | 1 | Bus write strobe, status register |
| stat_wdata_i | input | 2 | Bus write data bits 1:0 for the status register |
| din_wr_i | input | 1 | Bus write strobe, data-input register |
| rdata_o | output | 32 | Status read value |
| irq_o | output | 1 | Combined interrupt request, level |

## Verification
Set events and clear events can fall in the same cycle. A `digest_done_i` pulse can meet an `init_i` pulse or a zeroing status write. The free count can rise to 16 in the same cycle as a data-input write. The bench drives each of these pairs in one cycle. After the edge it expects the flag to be set, and in the following cycle it expects the interrupt to be raised when that flag is enabled. A scoreboard compares the read value and `irq_o` after every edge against a model built from the requirements.

// File: rtl/hsr_pkg.sv
package hsr_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned NUM_FLAGS = 2;
  localparam int unsigned BIT_DIN   = 0;
  localparam int unsigned BIT_DIG   = 1;
  localparam int unsigned BIT_DMA   = 2;
  localparam int unsigned BIT_BUSY  = 3;
  localparam int unsigned USED_W    = 4;
  typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/hsr_sticky_flag.sv
module hsr_sticky_flag #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_q <= RST_VAL;
    else if (set_i) q_q <= 1'b1;
    else if (clr_i) q_q <= 1'b0;
  end

  assign q_o = q_q;

  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
  assert_clear_takes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o);
  assert_hold_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/hsr_fill_edge.sv
module hsr_fill_edge #(
  parameter int unsigned FREE_W    = 5,
  parameter int unsigned BLK_WORDS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FREE_W-1:0] free_i,
  output logic              rise_o
);
  localparam logic [FREE_W-1:0] THRESH = FREE_W'(BLK_WORDS);

  logic room_now, room_q;

  assign room_now = (free_i >= THRESH);

  // prev starts high: buffer empty out of reset, flag already set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) room_q <= 1'b1;
    else         room_q <= room_now;
  end

  assign rise_o = room_now & ~room_q;

  assert_single_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/hsr_irq.sv
module hsr_irq #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] flag_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(flag_i & en_i);
  end

  assign irq_o = irq_q;

  assert_irq_level_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(flag_i & en_i)) |=> irq_o);
  assert_irq_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(flag_i & en_i)) |=> !irq_o);
endmodule

// File: rtl/hsr_top.sv
module hsr_top
  import hsr_pkg::*;
#(
  parameter int unsigned FREE_W    = 5,
  parameter int unsigned BLK_WORDS = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 core_busy_i,
  input  logic                 digest_done_i,
  input  logic [FREE_W-1:0]    fifo_free_i,
  input  logic                 dma_en_i,
  input  logic                 dma_xfer_i,
  input  logic                 init_i,
  input  logic                 ie_digest_i,
  input  logic                 ie_din_i,
  input  logic                 stat_wr_i,
  input  logic [NUM_FLAGS-1:0] stat_wdata_i,
  input  logic                 din_wr_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 irq_o
);
  localparam flag_vec_t FLAG_RST = flag_vec_t'(1 << BIT_DIN);

  flag_vec_t set_v, hw_clr_v, clr_v, flag_q, ie_v;
  logic      fill_rise;

  hsr_fill_edge #(.FREE_W(FREE_W), .BLK_WORDS(BLK_WORDS)) u_fill_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .free_i (fifo_free_i),
    .rise_o (fill_rise)
  );

  always_comb begin
    set_v             = '0;
    hw_clr_v          = '0;
    ie_v              = '0;
    set_v[BIT_DIN]    = fill_rise;
    set_v[BIT_DIG]    = digest_done_i;
    hw_clr_v[BIT_DIN] = din_wr_i;
    hw_clr_v[BIT_DIG] = init_i;
    ie_v[BIT_DIN]     = ie_din_i;
    ie_v[BIT_DIG]     = ie_digest_i;
  end

  // write-0-to-clear per bit, plus per-flag hardware clear
  assign clr_v = ({NUM_FLAGS{stat_wr_i}} & ~stat_wdata_i) | hw_clr_v;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    hsr_sticky_flag #(.RST_VAL(FLAG_RST[g])) u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_v[g]),
      .clr_i  (clr_v[g]),
      .q_o    (flag_q[g])
    );
  end

  hsr_irq #(.N(NUM_FLAGS)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flag_i (flag_q),
    .en_i   (ie_v),
    .irq_o  (irq_o)
  );

  always_comb begin
    rdata_o           = '0;
    rdata_o[BIT_DIN]  = flag_q[BIT_DIN];
    rdata_o[BIT_DIG]  = flag_q[BIT_DIG];
    rdata_o[BIT_DMA]  = dma_en_i | dma_xfer_i;
    rdata_o[BIT_BUSY] = core_busy_i;
  end

  assert_upper_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:USED_W] == '0);
  assert_dig_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    digest_done_i |=> rdata_o[BIT_DIG]);
  assert_din_wr_clr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (din_wr_i && !fill_rise) |=> !rdata_o[BIT_DIN]);
endmodule

// File: tb/hsr_top_bench.sv
`timescale 1ns/1ps
module hsr_top_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        busy = 0, dig_done = 0, dma_en = 0, dma_xfer = 0, init = 0;
  logic        ie_d = 0, ie_i = 0, stat_wr = 0, din_wr = 0;
  logic [1:0]  wdata = 2'b11;
  logic [4:0]  free = 5'd16;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  typedef struct { logic [31:0] rd; logic irq; string req; } item_t;
  item_t sb_q[$];

  // model state, from the requirements
  logic m_dig = 0, m_din = 1, m_ge_prev = 1;

  always #2.5 clk = ~clk;

  hsr_top u_hsr_top (
    .clk_i(clk), .rst_ni(rst_n), .core_busy_i(busy), .digest_done_i(dig_done),
    .fifo_free_i(free), .dma_en_i(dma_en), .dma_xfer_i(dma_xfer), .init_i(init),
    .ie_digest_i(ie_d), .ie_din_i(ie_i), .stat_wr_i(stat_wr), .stat_wdata_i(wdata),
    .din_wr_i(din_wr), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic cycle(input string req);
    item_t it;
    logic ge, dig_clr, din_clr;
    ge        = (free >= 5'd16);
    dig_clr   = (stat_wr & ~wdata[1]) | init;
    din_clr   = (stat_wr & ~wdata[0]) | din_wr;
    it.irq    = (m_dig & ie_d) | (m_din & ie_i);
    m_dig     = dig_done | (m_dig & ~dig_clr);
    m_din     = (ge & ~m_ge_prev) | (m_din & ~din_clr);
    m_ge_prev = ge;
    it.rd     = {28'd0, busy, dma_en | dma_xfer, m_dig, m_din};
    it.req    = req;
    sb_q.push_back(it);
    @(posedge clk);
    @(negedge clk);
    dig_done = 0; init = 0; stat_wr = 0; din_wr = 0; wdata = 2'b11;
  endtask

  // monitor: compare after each edge
  always @(posedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      item_t e;
      #1;
      e = sb_q.pop_front();
      n_chk++;
      if (rdata !== e.rd || irq !== e.irq) begin
        n_fail++;
        $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                 e.req, rdata, irq, e.rd, e.irq);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      n_fail++; n_chk++;
      $display("FAIL watchdog: cycles=%0d expected under 20000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (rdata !== 32'h1 || irq !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: rdata=%h irq=%b expected rdata=00000001 irq=0", rdata, irq);
    end
    rst_n = 1;
    cycle("R1 idle");
    busy = 1; cycle("R2 busy high");
    busy = 0; cycle("R2 busy low");
    dma_en = 1; ie_d = 1; cycle("R3 dma enable");
    dma_en = 0; dma_xfer = 1; cycle("R3 transfer tail");
    dma_xfer = 0; cycle("R3 dma idle");
    stat_wr = 1; wdata = 2'b11; cycle("R8 write ones");
    stat_wr = 1; wdata = 2'b10; cycle("R7 write zero bit0");
    repeat (3) cycle("R11 stays clear while empty");
    free = 5'd3; cycle("R6 buffer partly full");
    free = 5'd16; ie_i = 1; cycle("R6 room for block");
    cycle("R10 irq from input flag");
    din_wr = 1; cycle("R7 din write clears");
    cycle("R10 irq drops");
    dig_done = 1; cycle("R4 digest set");
    cycle("R10 irq from digest");
    stat_wr = 1; wdata = 2'b01; cycle("R5 write zero bit1");
    dig_done = 1; cycle("R4 digest again");
    init = 1; cycle("R5 init clears");
    dig_done = 1; init = 1; cycle("R9 digest vs init");
    dig_done = 1; stat_wr = 1; wdata = 2'b00; cycle("R9 digest vs write zero");
    free = 5'd7; cycle("R6 drain");
    free = 5'd20; din_wr = 1; cycle("R9 fill vs din write");
    ie_d = 0; ie_i = 0; cycle("R10 masked");
    cycle("R10 masked quiet");
    dma_en = 1; busy = 1; cycle("R3 no irq effect");
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule